// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns a memory reference into a linear address using the hidden state held by one segment register: its base, its limit and a usable flag. The caller presents the three parts of the effective offset (a base register value, an index value and a displacement), an address-size mode and an access width in bytes. The block sums the three parts and truncates the sum to 16 bits when the reference uses 16-bit addressing. It then checks that every byte of the access lies at or below the segment limit and adds the segment base. The selector value is not an input and plays no part in forming the address.

Whether an access faults depends on the loaded limit, not on the address-size mode. A word access at offset FFFFh faults against a 64 KB limit and succeeds against a 4 GB limit. A 32-bit offset is accepted in either mode, and only the limit decides whether it faults. The result comes back one clock after the request strobe as either a valid strobe with the linear address or a fault strobe.

Top module: `seg_lin_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, rsp_valid and rsp_fault are 0 and lin_addr is 0.
- R2: The offset is off_base + off_index + off_disp. When addr_32 is 1 the sum is taken modulo 2^32. When addr_32 is 0 only the low 16 bits of the sum are kept, so 7000h+7000h+7000h gives offset 5000h.
- R3: On a successful access, lin_addr equals seg_base + offset modulo 2^32.
- R4: The access faults when offset + acc_width - 1 is greater than seg_limit. The comparison is made without overflow. A word at offset FFFFh therefore faults with limit FFFFh and succeeds with limit FFFFFFFFh.
- R5: A request through a segment with seg_usable = 0 faults.
- R6: acc_width is a byte count. Only the values 1, 2 and 4 are legal, and any other value faults.
- R7: Exactly one of rsp_valid and rsp_fault is high in the cycle after req_valid is high. Both are low in the cycle after req_valid is low.
- R8: lin_addr changes only together with rsp_valid. After a fault, or a cycle with no request, it keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| addr_32 | input | 1 | 1: 32-bit addressing, 0: 16-bit addressing |
| off_base | input | 32 | Base register part of the offset |
| off_index | input | 32 | Index part of the offset |
| off_disp | input | 32 | Displacement part of the offset |
| acc_width | input | 3 | Access size in bytes (1, 2 or 4) |
| seg_base | input | 32 | Hidden base of the selected segment |
| seg_limit | input | 32 | Hidden limit of the segment (length minus one) |
| seg_usable | input | 1 | Segment usable flag |
| lin_addr | output | 32 | Linear address of the last successful access |
| rsp_valid | output | 1 | Access accepted, registered one cycle after request |
| rsp_fault | output | 1 | Access rejected, registered one cycle after request |

## Verification
The hardest cases to reach from the ports are those where the end of the access crosses a 32-bit boundary: the offset is near FFFFFFFFh and the limit is the full 4 GB, so an end computed at 32 bits would wrap and pass. Random operands almost never land there, so directed requests place the offset at FFFFFFFFh and FFFFFFFEh with word and doubleword widths. Further directed requests cover 16-bit wraps of the component sum, a base-plus-offset carry out of bit 31, and an access that ends exactly on the limit. Random traffic with limits biased towards FFFFh and FFFFFFFFh then covers the mixtures of these cases.

// File: rtl/sla_pkg.sv
// Package: shared sizes and the access-width legality rule for the
// segmented linear address generator. Assumes widths are byte counts.
package sla_pkg;
    localparam int unsigned SLA_ADDR_W  = 32;
    localparam int unsigned SLA_SHORT_W = 16;
    localparam int unsigned SLA_WID_W   = 3;

    // Legal access sizes in bytes.
    function automatic logic width_legal(input logic [SLA_WID_W-1:0] w);
        return (w == 3'd1) || (w == 3'd2) || (w == 3'd4);
    endfunction
endpackage

// File: rtl/sla_offset_calc.sv
// Module: sums the three offset components and, for short addressing,
// keeps only the low SHORT_W bits. Purely combinational.
// Assumes SHORT_W < ADDR_W.
module sla_offset_calc #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned SHORT_W = 16
) (
    input  logic              wide_mode,
    input  logic [ADDR_W-1:0] part_a,
    input  logic [ADDR_W-1:0] part_b,
    input  logic [ADDR_W-1:0] part_c,
    output logic [ADDR_W-1:0] offset
);
    localparam int unsigned HI_W = ADDR_W - SHORT_W;

    logic [ADDR_W-1:0] raw_sum;

    // Full-width modular sum of the components.
    always_comb begin
        raw_sum = part_a + part_b + part_c;
    end

    // Truncate in short mode; upper bits forced to zero.
    always_comb begin
        if (wide_mode) begin
            offset = raw_sum;
        end else begin
            offset = {{HI_W{1'b0}}, raw_sum[SHORT_W-1:0]};
        end
    end

    // R2: short-mode offsets never carry bits above the short width.
    always_comb begin
        a_r2_short_trunc: assert (wide_mode || offset[ADDR_W-1:SHORT_W] == '0);
    end
endmodule

// File: rtl/sla_limit_check.sv
// Module: decides whether an access of `width` bytes starting at `offset`
// lies within the segment limit, and whether the segment and width are
// acceptable. The end address is formed one bit wider than the address
// so that it cannot wrap. Combinational.
module sla_limit_check #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned WID_W  = 3
) (
    input  logic              [ADDR_W-1:0] offset,
    input  logic              [WID_W-1:0]  width,
    input  logic              [ADDR_W-1:0] limit,
    input  logic                           usable,
    output logic                           fault
);
    import sla_pkg::*;

    localparam int unsigned EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] last_byte;
    logic             over_limit;
    logic             bad_width;

    // Offset of the final byte touched, at extended width.
    always_comb begin
        last_byte = {1'b0, offset} + EXT_W'(width) - EXT_W'(1);
    end

    // Inclusive limit comparison and width legality.
    always_comb begin
        over_limit = last_byte > {1'b0, limit};
        bad_width  = !width_legal(width);
        fault      = over_limit || bad_width || !usable;
    end
endmodule

// File: rtl/seg_lin_addr_gen.sv
// Module: top of the segmented linear address generator. Forms the
// offset, checks it against the hidden limit, adds the hidden base and
// registers a valid or fault strobe one cycle after each request.
// Assumes the segment state inputs are stable in the request cycle.
module seg_lin_addr_gen #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned SHORT_W = 16,
    parameter int unsigned WID_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              addr_32,
    input  logic [ADDR_W-1:0] off_base,
    input  logic [ADDR_W-1:0] off_index,
    input  logic [ADDR_W-1:0] off_disp,
    input  logic [WID_W-1:0]  acc_width,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic              seg_usable,
    output logic [ADDR_W-1:0] lin_addr,
    output logic              rsp_valid,
    output logic              rsp_fault
);
    logic [ADDR_W-1:0] eff_off;
    logic [ADDR_W-1:0] next_addr;
    logic              chk_fault;

    sla_offset_calc #(
        .ADDR_W (ADDR_W),
        .SHORT_W(SHORT_W)
    ) u_off (
        .wide_mode(addr_32),
        .part_a   (off_base),
        .part_b   (off_index),
        .part_c   (off_disp),
        .offset   (eff_off)
    );

    sla_limit_check #(
        .ADDR_W(ADDR_W),
        .WID_W (WID_W)
    ) u_chk (
        .offset(eff_off),
        .width (acc_width),
        .limit (seg_limit),
        .usable(seg_usable),
        .fault (chk_fault)
    );

    // Base plus offset, wrapping at the address width.
    always_comb begin
        next_addr = seg_base + eff_off;
    end

    // Response strobes and address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            lin_addr  <= '0;
        end else begin
            rsp_valid <= req_valid && !chk_fault;
            rsp_fault <= req_valid && chk_fault;
            if (req_valid && !chk_fault) begin
                lin_addr <= next_addr;
            end
        end
    end

    // R7: the two strobes never coincide.
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_fault));

    // R7: every request gets a response next cycle.
    a_r7_answer: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_valid || rsp_fault));

    // R7: no response without a request.
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(rsp_valid || rsp_fault));

    // R5: unusable segments always fault.
    a_r5_unusable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !seg_usable) |=> rsp_fault);

    // R8: the address only moves with a valid strobe.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> $stable(lin_addr));
endmodule

// File: tb/seg_lin_addr_gen_tb_top.sv
// Bench: behavioural reference model compared against the outputs every
// clock. Inputs are driven at the falling edge; outputs sampled at the
// next falling edge.
module seg_lin_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        addr_32;
    logic [31:0] off_base, off_index, off_disp;
    logic [2:0]  acc_width;
    logic [31:0] seg_base, seg_limit;
    logic        seg_usable;
    logic [31:0] lin_addr;
    logic        rsp_valid, rsp_fault;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] m_addr;
    logic        m_valid, m_fault;

    always #5 clk = ~clk;

    seg_lin_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .addr_32(addr_32),
        .off_base(off_base), .off_index(off_index), .off_disp(off_disp),
        .acc_width(acc_width), .seg_base(seg_base), .seg_limit(seg_limit),
        .seg_usable(seg_usable), .lin_addr(lin_addr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Model update for one clock, from the requirement text.
    task automatic model_step();
        longint off, last;
        bit ok;
        if (!rst_n) begin
            m_valid = 0; m_fault = 0; m_addr = 0;
            return;
        end
        off = longint'(off_base) + longint'(off_index) + longint'(off_disp);
        off = addr_32 ? (off % 64'h1_0000_0000) : (off % 64'h1_0000);
        last = off + longint'(acc_width) - 1;
        ok = seg_usable && (acc_width == 1 || acc_width == 2 || acc_width == 4)
             && (last <= longint'(seg_limit));
        m_valid = req_valid && ok;
        m_fault = req_valid && !ok;
        if (m_valid) m_addr = 32'((longint'(seg_base) + off) % 64'h1_0000_0000);
    endtask

    task automatic cycle(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check({tag, " R7 valid"}, rsp_valid, m_valid);
        check({tag, " R7 fault"}, rsp_fault, m_fault);
        check({tag, " R3/R8 addr"}, lin_addr, m_addr);
    endtask

    task automatic req(input string tag, input bit a32, input logic [31:0] b,
                       input logic [31:0] i, input logic [31:0] d, input logic [2:0] w,
                       input logic [31:0] sb, input logic [31:0] lim, input bit u);
        req_valid = 1; addr_32 = a32; off_base = b; off_index = i; off_disp = d;
        acc_width = w; seg_base = sb; seg_limit = lim; seg_usable = u;
        cycle(tag);
        req_valid = 0;
    endtask

    initial begin
        #200000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; req_valid = 0; addr_32 = 0; off_base = 0; off_index = 0;
        off_disp = 0; acc_width = 1; seg_base = 0; seg_limit = 0; seg_usable = 1;
        @(negedge clk);
        cycle("R1 reset");
        check("R1 reset valid", rsp_valid, 0);
        check("R1 reset addr", lin_addr, 0);
        rst_n = 1;
        cycle("R7 idle");
        // R2: 16-bit wrap of the component sum
        req("R2 wrap16", 0, 32'h7000, 32'h7000, 32'h7000, 1, 32'h12340, 32'hFFFF, 1);
        check("R2 wrap16 addr", lin_addr, 32'h17340);
        // R4: word at FFFF against 64K limit faults
        req("R4 word64k", 0, 32'hFFFF, 0, 0, 2, 32'h1000, 32'hFFFF, 1);
        check("R4 word64k fault", rsp_fault, 1);
        check("R8 hold after fault", lin_addr, 32'h17340);
        // R4: same access against 4G limit succeeds
        req("R4 word4g", 0, 32'hFFFF, 0, 0, 2, 32'h1000, 32'hFFFF_FFFF, 1);
        check("R4 word4g addr", lin_addr, 32'h10FFF);
        // R4: ends exactly on limit
        req("R4 exact", 0, 32'hFFFE, 0, 0, 2, 0, 32'hFFFF, 1);
        check("R4 exact valid", rsp_valid, 1);
        // R4: 32-bit offset, small and large limit
        req("R4 big off", 1, 32'h0010_0000, 0, 0, 4, 0, 32'hFFFF, 1);
        check("R4 big off fault", rsp_fault, 1);
        req("R4 big off ok", 1, 32'h0010_0000, 0, 4, 4, 0, 32'hFFFF_FFFF, 1);
        check("R4 big off addr", lin_addr, 32'h0010_0004);
        // R4: end crosses 2^32 with full limit
        req("R4 top word", 1, 32'hFFFF_FFFF, 0, 0, 2, 0, 32'hFFFF_FFFF, 1);
        check("R4 top word fault", rsp_fault, 1);
        req("R4 top dword", 1, 32'hFFFF_FFFE, 0, 0, 4, 0, 32'hFFFF_FFFF, 1);
        check("R4 top dword fault", rsp_fault, 1);
        req("R4 top byte", 1, 32'hFFFF_FFFF, 0, 0, 1, 0, 32'hFFFF_FFFF, 1);
        check("R4 top byte valid", rsp_valid, 1);
        // R3: base plus offset wraps
        req("R3 wrap", 1, 32'h10, 32'h10, 0, 1, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 1);
        check("R3 wrap addr", lin_addr, 32'h10);
        // R2: 32-bit component sum wraps modulo 2^32
        req("R2 wrap32", 1, 32'hFFFF_FFFF, 32'h2, 0, 1, 32'h100, 32'hFFFF, 1);
        check("R2 wrap32 addr", lin_addr, 32'h101);
        // R5: unusable segment
        req("R5 unusable", 1, 0, 0, 0, 1, 0, 32'hFFFF_FFFF, 0);
        check("R5 unusable fault", rsp_fault, 1);
        // R6: illegal widths
        req("R6 width3", 1, 0, 0, 0, 3, 0, 32'hFFFF_FFFF, 1);
        check("R6 width3 fault", rsp_fault, 1);
        req("R6 width0", 1, 32'h40, 0, 0, 0, 0, 32'hFFFF_FFFF, 1);
        check("R6 width0 fault", rsp_fault, 1);
        // Random mixture
        for (int n = 0; n < 400; n++) begin
            int unsigned r = $urandom;
            req_valid  = r[0];
            addr_32    = r[1];
            off_base   = r[2] ? 32'hFFFF_FFF0 + {28'd0, r[7:4]} : $urandom;
            off_index  = r[3] ? 32'd0 : $urandom;
            off_disp   = $urandom_range(0, 8);
            acc_width  = r[10:8];
            seg_base   = $urandom;
            seg_limit  = r[11] ? 32'hFFFF_FFFF : (r[12] ? 32'hFFFF : $urandom);
            seg_usable = r[15:13] != 0;
            cycle("R2-random");
        end
        req_valid = 0;
        cycle("R7 final idle");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule